// File: doc/BRIEF.md
# Fan Tachometer Speed Meter

This block turns a fan's digital tachometer pulse train into a speed in revolutions per minute. A prescaler derives a fixed-rate timebase tick from the system clock, and a tick counter measures the time between rising tachometer edges. The measured interval goes through a multi-cycle restoring divider that computes RPM for a sensor giving two pulses per revolution on a 120 kHz timebase.

A measurement runs only when an external voter asks for one. The voter pulses a start request. The block then throws away the first edge it sees, because the interval up to that edge is a partial period. It times the next full period, divides, and raises a result-valid flag. That flag stays up until the voter's next request. If the fan stops, the tick counter reaches a stall limit before an edge arrives. The block then reports zero RPM with a stall flag and still completes the handshake.

Top module: `tach_speed_meter`

## Requirements
- R1: After reset, readyOut, stallOut and rpmOut are all 0, and tachometer edges without a start request never raise readyOut.
- R2: After an accepted goIn pulse, the first rising tachometer edge is discarded. With N timebase ticks (one tick per TICK_CLKS clocks) between the first and second rising edges, rpmOut equals floor(TICK_HZ*60 / (PULSES_PER_REV*N)), which is floor(3600000/N) by default.
- R3: readyOut rises only once the division has finished. It is still low 20 clocks after the measuring edge reaches tachIn and is high within 40 clocks of it.
- R4: Once readyOut is high, it stays high and rpmOut and stallOut stay unchanged until the next goIn, even while tachometer edges keep arriving. readyOut is low from the cycle after an accepted goIn.
- R5: A goIn pulse that arrives while a measurement or division is in progress is ignored: the result and its timing are those of the original request.
- R6: If STALL_LIMIT ticks pass with no rising edge, counted from the accepted goIn or from the discarded edge, the block sets rpmOut to 0, sets stallOut to 1 and raises readyOut. It does not do so earlier.
- R7: A successful measurement clears stallOut to 0.
- R8: The ends of the supported speed range convert exactly: N=1200 gives 3000 and N=3600 gives 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tachIn | input | 1 | Raw tachometer line, asynchronous to clk |
| goIn | input | 1 | One-cycle measurement request from the voter |
| rpmOut | output | RPM_W (22) | Measured speed in RPM, 0 on stall |
| readyOut | output | 1 | Result valid, held until the next accepted request |
| stallOut | output | 1 | Last result came from the stall limit |

## Verification
The bench sweeps the tachometer period across the supported speed range, including odd counts where the division rounds down. Each result is compared with an integer division done in the bench. This means any error in the tick count, an off-by-one capture or a wrong divider step shows up in rpmOut at the first readyOut that follows. A sequencer that restarts on a busy request, or fails to discard the partial period, changes when readyOut rises. That error therefore appears within one tachometer period, either as a missing ready or as a stall. A wrong counter limit shifts the stall report outside a 20-clock window around STALL_LIMIT ticks.

// File: rtl/tach_pkg.sv
package tach_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_MEAS,
    S_LOAD,
    S_DIV,
    S_DONE
  } tach_state_t;

  typedef struct packed {
    logic clrCnt;
    logic divStart;
    logic loadZero;
    logic loadResult;
  } tach_strobe_t;

  typedef struct packed {
    logic edgeSeen;
    logic stallHit;
    logic divDone;
  } tach_status_t;

endpackage

// File: rtl/tach_divider.sv
module tach_divider #(
  parameter int DVD_W = 22,
  parameter int DVS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quotient,
  output logic             done
);

  localparam int SW = (DVD_W > 1) ? $clog2(DVD_W) : 1;

  logic [DVS_W-1:0] remQ;
  logic [DVS_W-1:0] dvsQ;
  logic [DVD_W-1:0] quoQ;
  logic [SW-1:0]    stepQ;
  logic             busyQ;
  logic [DVS_W:0]   shifted;
  logic [DVS_W:0]   diff;
  logic             geq;

  always_comb begin
    shifted = {remQ, quoQ[DVD_W-1]};
    geq     = shifted >= {1'b0, dvsQ};
    diff    = shifted - {1'b0, dvsQ};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remQ  <= '0;
      dvsQ  <= '0;
      quoQ  <= '0;
      stepQ <= '0;
      busyQ <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remQ  <= '0;
        dvsQ  <= divisor;
        quoQ  <= dividend;
        stepQ <= '0;
        busyQ <= 1'b1;
      end else if (busyQ) begin
        remQ  <= geq ? diff[DVS_W-1:0] : shifted[DVS_W-1:0];
        quoQ  <= {quoQ[DVD_W-2:0], geq};
        stepQ <= stepQ + 1'b1;
        if (stepQ == SW'(DVD_W - 1)) begin
          busyQ <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quotient = quoQ;

  // R2
  div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvsQ != '0) |->
      ((64'(quoQ) * 64'(dvsQ) <= 64'(dividend)) &&
       (64'(dividend) - 64'(quoQ) * 64'(dvsQ) < 64'(dvsQ))));

endmodule

// File: rtl/tach_datapath.sv
module tach_datapath import tach_pkg::*; #(
  parameter int TICK_CLKS   = 1000,
  parameter int STALL_LIMIT = 16383,
  parameter int CNT_W       = 14,
  parameter int RPM_W       = 22,
  parameter int RPM_CONST   = 3600000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tachIn,
  input  tach_strobe_t       strobe,
  output tach_status_t       status,
  output logic [RPM_W-1:0]   rpmOut,
  output logic               stallOut
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STALL_LIMIT);

  logic [2:0]       syncQ;
  logic             rise;
  logic             tick;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] capVal;
  logic [CNT_W-1:0] periodQ;
  logic [RPM_W-1:0] quotient;
  logic             divDone;
  logic             atLimit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[1:0], tachIn};
  end

  assign rise = syncQ[1] & ~syncQ[2];

  generate
    if (TICK_CLKS <= 1) begin : g_fullRate
      assign tick = 1'b1;
    end else begin : g_prescale
      localparam int PW = $clog2(TICK_CLKS);
      logic [PW-1:0] preQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         preQ <= '0;
        else if (preQ == PW'(TICK_CLKS-1))  preQ <= '0;
        else                                preQ <= preQ + 1'b1;
      end
      assign tick = (preQ == PW'(TICK_CLKS-1));
    end
  endgenerate

  assign atLimit = (cntQ == LIMIT_V);
  assign capVal  = (tick && !atLimit) ? cntQ + 1'b1 : cntQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cntQ <= '0;
    else if (strobe.clrCnt || rise)   cntQ <= '0;
    else if (tick && !atLimit)        cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    periodQ <= '0;
    else if (rise) periodQ <= capVal;
  end

  tach_divider #(
    .DVD_W (RPM_W),
    .DVS_W (CNT_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (strobe.divStart),
    .dividend (RPM_W'(RPM_CONST)),
    .divisor  (periodQ),
    .quotient (quotient),
    .done     (divDone)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpmOut   <= '0;
      stallOut <= 1'b0;
    end else if (strobe.loadZero) begin
      rpmOut   <= '0;
      stallOut <= 1'b1;
    end else if (strobe.loadResult) begin
      rpmOut   <= quotient;
      stallOut <= 1'b0;
    end
  end

  assign status.edgeSeen = rise;
  assign status.stallHit = atLimit;
  assign status.divDone  = divDone;

  // R6
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= LIMIT_V);

  // R6
  stall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stallOut |-> (rpmOut == '0));

  // R6
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stallOut) |-> $past(atLimit));

endmodule

// File: rtl/tach_ctrl.sv
module tach_ctrl import tach_pkg::*; (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         goIn,
  input  tach_status_t status,
  output tach_strobe_t strobe,
  output logic         readyOut
);

  tach_state_t stateQ;
  tach_state_t stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = stateQ;
    case (stateQ)
      S_IDLE, S_DONE: begin
        if (goIn) begin
          strobe.clrCnt = 1'b1;
          stateNxt      = S_ARM;
        end
      end
      S_ARM: begin
        if (status.edgeSeen) begin
          stateNxt = S_MEAS;
        end else if (status.stallHit) begin
          strobe.loadZero = 1'b1;
          stateNxt        = S_DONE;
        end
      end
      S_MEAS: begin
        if (status.edgeSeen) begin
          stateNxt = S_LOAD;
        end else if (status.stallHit) begin
          strobe.loadZero = 1'b1;
          stateNxt        = S_DONE;
        end
      end
      S_LOAD: begin
        strobe.divStart = 1'b1;
        stateNxt        = S_DIV;
      end
      S_DIV: begin
        if (status.divDone) begin
          strobe.loadResult = 1'b1;
          stateNxt          = S_DONE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= S_IDLE;
    else        stateQ <= stateNxt;
  end

  assign readyOut = (stateQ == S_DONE);

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readyOut && goIn) |=> !readyOut);

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readyOut && !goIn) |=> readyOut);

  // R3
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(readyOut) |-> $past(status.divDone || status.stallHit));

  // R5
  busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == S_MEAS || stateQ == S_LOAD || stateQ == S_DIV) |=> (stateQ != S_ARM));

endmodule

// File: rtl/tach_speed_meter.sv
module tach_speed_meter import tach_pkg::*; #(
  parameter int TICK_CLKS      = 1000,
  parameter int TICK_HZ        = 120000,
  parameter int PULSES_PER_REV = 2,
  parameter int STALL_LIMIT    = 16383,
  localparam int RPM_CONST     = TICK_HZ * 60 / PULSES_PER_REV,
  localparam int RPM_W         = $clog2(RPM_CONST + 1),
  localparam int CNT_W         = $clog2(STALL_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tachIn,
  input  logic             goIn,
  output logic [RPM_W-1:0] rpmOut,
  output logic             readyOut,
  output logic             stallOut
);

  tach_strobe_t strobe;
  tach_status_t status;

  tach_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .goIn     (goIn),
    .status   (status),
    .strobe   (strobe),
    .readyOut (readyOut)
  );

  tach_datapath #(
    .TICK_CLKS   (TICK_CLKS),
    .STALL_LIMIT (STALL_LIMIT),
    .CNT_W       (CNT_W),
    .RPM_W       (RPM_W),
    .RPM_CONST   (RPM_CONST)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tachIn   (tachIn),
    .strobe   (strobe),
    .status   (status),
    .rpmOut   (rpmOut),
    .stallOut (stallOut)
  );

endmodule

// File: tb/tb_tach_speed_meter.sv
`timescale 1ns/1ps
module tb_tach_speed_meter;

  localparam int TCK = 2;
  localparam int LIM = 8191;
  localparam int RW  = 22;
  localparam int NUM = 3600000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tachIn = 1'b0;
  logic          goIn = 1'b0;
  logic [RW-1:0] rpmOut;
  logic          readyOut;
  logic          stallOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  tach_speed_meter #(
    .TICK_CLKS   (TCK),
    .STALL_LIMIT (LIM)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tachIn   (tachIn),
    .goIn     (goIn),
    .rpmOut   (rpmOut),
    .readyOut (readyOut),
    .stallOut (stallOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung act=%0d cycles exp<=190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic pulseGo();
    goIn = 1'b1;
    @(negedge clk);
    goIn = 1'b0;
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // mode 0: plain, 1: GO while waiting for second edge, 2: GO during divide
  task automatic measure(input int n, input int mode, input string tag);
    int waited;
    pulseGo();
    clks(4);
    check(readyOut == 1'b0, "R4 ready low after go", readyOut, 0);
    tachIn = 1'b1;
    clks(n * TCK / 2);
    tachIn = 1'b0;
    if (mode == 1) begin
      clks(n * TCK / 4);
      pulseGo();
      clks(n * TCK / 2 - n * TCK / 4 - 1);
    end else begin
      clks(n * TCK / 2);
    end
    tachIn = 1'b1;
    if (mode == 2) begin
      clks(8);
      pulseGo();
      clks(11);
    end else begin
      clks(20);
    end
    tachIn = 1'b0;
    check(readyOut == 1'b0, "R3 ready not early", readyOut, 0);
    waited = 20;
    while (!readyOut && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check(readyOut == 1'b1, "R3 ready within bound", waited, 40);
    check(rpmOut == RW'(NUM / n), tag, int'(rpmOut), NUM / n);
    check(stallOut == 1'b0, "R7 stall clear after result", stallOut, 0);
    if (mode == 2) begin
      clks(100);
      check(readyOut == 1'b1, "R5 go during divide ignored", readyOut, 1);
    end
  endtask

  initial begin
    int held;
    clks(3);
    rst_n = 1'b1;
    clks(2);
    // R1
    check(readyOut == 1'b0, "R1 reset ready", readyOut, 0);
    check(stallOut == 1'b0, "R1 reset stall", stallOut, 0);
    check(rpmOut == '0, "R1 reset rpm", int'(rpmOut), 0);
    for (int p = 0; p < 3; p++) begin
      tachIn = 1'b1; clks(300); tachIn = 1'b0; clks(300);
    end
    check(readyOut == 1'b0, "R1 edges without go", readyOut, 0);

    // R8 range ends
    measure(1200, 0, "R8 rpm at period 1200");
    measure(3600, 0, "R8 rpm at period 3600");

    // R6 stall before any edge
    pulseGo();
    clks(TCK * LIM - 12);
    check(readyOut == 1'b0, "R6 no early stall from go", readyOut, 0);
    clks(24);
    check(readyOut == 1'b1, "R6 stall ready", readyOut, 1);
    check(stallOut == 1'b1, "R6 stall flag", stallOut, 1);
    check(rpmOut == '0, "R6 stall rpm zero", int'(rpmOut), 0);

    // R7 recovery
    measure(2500, 0, "R7 rpm after stall");

    // R2 sweep
    for (int n = 1400; n <= 3400; n += 200) measure(n, 0, "R2 rpm sweep");
    measure(1201, 0, "R2 rpm odd 1201");
    measure(3599, 0, "R2 rpm odd 3599");
    measure(2999, 0, "R2 rpm odd 2999");

    // R4 hold while edges continue
    held = int'(rpmOut);
    for (int p = 0; p < 4; p++) begin
      tachIn = 1'b1; clks(250); tachIn = 1'b0; clks(250);
    end
    check(readyOut == 1'b1, "R4 ready held", readyOut, 1);
    check(int'(rpmOut) == held, "R4 rpm held", int'(rpmOut), held);
    check(stallOut == 1'b0, "R4 stall held", stallOut, 0);

    // R5 busy requests
    measure(2000, 1, "R5 rpm with go in measure");
    measure(1800, 2, "R5 rpm with go in divide");

    // R6 stall after the discarded edge
    pulseGo();
    clks(4);
    tachIn = 1'b1; clks(10); tachIn = 1'b0;
    clks(TCK * LIM - 20);
    check(readyOut == 1'b0, "R6 no early stall from edge", readyOut, 0);
    clks(24);
    check(readyOut == 1'b1, "R6 stall ready after edge", readyOut, 1);
    check(stallOut == 1'b1, "R6 stall flag after edge", stallOut, 1);
    check(rpmOut == '0, "R6 rpm zero after edge", int'(rpmOut), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule